// File: doc/BRIEF.md
# Branch and Call Next-PC Unit

This block decides where a 32-bit processor fetches next after one instruction. Each cycle it may accept the address of the current instruction, the instruction word and the two source register values. One cycle later it returns the next fetch address, a flag that says whether control flow was redirected, and, for calls, a request to write the return address into the link register. Register reads, the register file write and the fetch itself stay outside the block.

Three kinds of redirect are recognised from the 6-bit major opcode in bits 31:26. The first kind is a compare-and-branch on the two register values, which uses a signed 16-bit word displacement held in bits 15:0. The second is a relative jump or call, which uses a signed 26-bit word displacement held in bits 25:0. The third jumps to the address held in the first source register. Any return instruction is an ordinary register jump whose source happens to be the link register. Every other opcode falls through to the next sequential word.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output register is cleared: `out_valid_o`, `taken_o` and `link_we_o` are 0, and `next_pc_o`, `link_idx_o` and `link_val_o` are 0.
- R2: An instruction presented with `in_valid_i` high is answered on the outputs after exactly one rising edge, with `out_valid_o` high. A cycle with `in_valid_i` low produces `out_valid_o`, `taken_o` and `link_we_o` all low on the next cycle.
- R3: Opcode 17 is taken when the two register values are equal. Opcode 23 is taken when they differ.
- R4: Opcode 18 is taken when the first value is greater than the second under two's-complement compare. Opcode 19 is taken when it is greater or equal under the same compare.
- R5: Opcode 21 is taken when the first value is greater than the second as unsigned numbers. Opcode 20 is taken when it is greater or equal as unsigned numbers.
- R6: A taken compare-and-branch goes to the instruction address plus bits 15:0 shifted left by two and sign-extended from the resulting bit 17.
- R7: A compare-and-branch whose condition fails gives `next_pc_o` equal to the instruction address plus 4, with `taken_o` low.
- R8: Opcodes 56 (relative jump) and 62 (relative call) are always taken. Their target is the instruction address plus bits 25:0 shifted left by two and sign-extended from the resulting bit 27.
- R9: Opcodes 54 and 62 (the two call forms) raise `link_we_o`, set `link_idx_o` to 29 and set `link_val_o` to the instruction address plus 4. No other opcode raises `link_we_o`, and in that case `link_idx_o` and `link_val_o` are 0.
- R10: Opcodes 48 (register jump) and 54 (register call) are always taken. Their target is the first register value with bits 1:0 cleared.
- R11: Any opcode not named in R3 to R10 gives `next_pc_o` equal to the instruction address plus 4, with `taken_o` and `link_we_o` low.
- R12: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | An instruction is presented this cycle |
| pc_i | input | 32 | Address of the presented instruction |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 32 | Value of the first source register |
| rb_val_i | input | 32 | Value of the second source register |
| out_valid_o | output | 1 | The result outputs belong to the instruction accepted one cycle earlier |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control flow was redirected |
| link_we_o | output | 1 | Request to write the link register |
| link_idx_o | output | 5 | Register index for the link write |
| link_val_o | output | 32 | Return address to write |

## Verification
The clocked checks compare each output with the inputs sampled one cycle earlier. They therefore assume that `pc_i`, `insn_i` and both register values are stable across the edge at which `in_valid_i` is high, and that `rst` is low at that edge. The bench meets this by changing inputs only on falling edges, holding each instruction for a single sampled edge, and never asserting reset while a result is pending. Instruction addresses in the stimulus are word-aligned, because the relative targets inherit the alignment of the instruction address.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W   = 6;
    localparam int BOFF_W  = 16;
    localparam int JOFF_W  = 26;
    localparam int INSN_W  = 32;

    typedef logic [OPC_W-1:0] opc_t;

    // Major opcodes that redirect control flow
    localparam opc_t OPC_BR_EQ  = 6'd17;
    localparam opc_t OPC_BR_GT  = 6'd18;
    localparam opc_t OPC_BR_GE  = 6'd19;
    localparam opc_t OPC_BR_GEU = 6'd20;
    localparam opc_t OPC_BR_GTU = 6'd21;
    localparam opc_t OPC_BR_NE  = 6'd23;
    localparam opc_t OPC_JREG   = 6'd48;
    localparam opc_t OPC_CREG   = 6'd54;
    localparam opc_t OPC_JREL   = 6'd56;
    localparam opc_t OPC_CREL   = 6'd62;

    typedef enum logic [1:0] {
        FLOW_SEQ  = 2'd0,
        FLOW_COND = 2'd1,
        FLOW_REL  = 2'd2,
        FLOW_REG  = 2'd3
    } flow_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_GT  = 3'd2,
        CMP_GE  = 3'd3,
        CMP_GTU = 3'd4,
        CMP_GEU = 3'd5
    } cmp_e;

    typedef struct packed {
        flow_e flow;
        cmp_e  cmp;
        logic  link;
    } flow_dec_t;

    function automatic flow_dec_t decode_opc(input opc_t opc);
        flow_dec_t d;
        d.flow = FLOW_SEQ;
        d.cmp  = CMP_EQ;
        d.link = 1'b0;
        case (opc)
            OPC_BR_EQ:  begin d.flow = FLOW_COND; d.cmp = CMP_EQ;  end
            OPC_BR_NE:  begin d.flow = FLOW_COND; d.cmp = CMP_NE;  end
            OPC_BR_GT:  begin d.flow = FLOW_COND; d.cmp = CMP_GT;  end
            OPC_BR_GE:  begin d.flow = FLOW_COND; d.cmp = CMP_GE;  end
            OPC_BR_GTU: begin d.flow = FLOW_COND; d.cmp = CMP_GTU; end
            OPC_BR_GEU: begin d.flow = FLOW_COND; d.cmp = CMP_GEU; end
            OPC_JREL:   begin d.flow = FLOW_REL; end
            OPC_CREL:   begin d.flow = FLOW_REL; d.link = 1'b1; end
            OPC_JREG:   begin d.flow = FLOW_REG; end
            OPC_CREG:   begin d.flow = FLOW_REG; d.link = 1'b1; end
            default:    d.flow = FLOW_SEQ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output flow_dec_t        dec_o
);
    always_comb begin
        dec_o = decode_opc(opc_i);
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  cmp_e            cmp_i,
    output logic            hit_o
);
    logic eq, gt_s, gt_u;

    always_comb begin
        eq   = (a_i == b_i);
        gt_s = ($signed(a_i) > $signed(b_i));
        gt_u = (a_i > b_i);
        case (cmp_i)
            CMP_EQ:  hit_o = eq;
            CMP_NE:  hit_o = !eq;
            CMP_GT:  hit_o = gt_s;
            CMP_GE:  hit_o = gt_s || eq;
            CMP_GTU: hit_o = gt_u;
            CMP_GEU: hit_o = gt_u || eq;
            default: hit_o = 1'b0;
        endcase
    end

    // Equality and strict order exclude each other
    always_comb begin
        assert (!(eq && (gt_s || gt_u))); // R3
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [JOFF_W-1:0] fld_i,
    input  logic [XLEN-1:0]   ra_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   cond_tgt_o,
    output logic [XLEN-1:0]   rel_tgt_o,
    output logic [XLEN-1:0]   reg_tgt_o
);
    localparam int BSPAN = BOFF_W + 2;
    localparam int JSPAN = JOFF_W + 2;

    logic [XLEN-1:0] boff, joff;

    always_comb begin
        boff       = {{(XLEN-BSPAN){fld_i[BOFF_W-1]}}, fld_i[BOFF_W-1:0], 2'b00};
        joff       = {{(XLEN-JSPAN){fld_i[JOFF_W-1]}}, fld_i, 2'b00};
        seq_o      = pc_i + XLEN'(4);
        cond_tgt_o = pc_i + boff;
        rel_tgt_o  = pc_i + joff;
        reg_tgt_o  = {ra_i[XLEN-1:2], 2'b00};
    end

    always_comb begin
        assert (reg_tgt_o[1:0] == 2'b00); // R10
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RIDX_W    = 5,
    parameter int LINK_REG  = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   ra_val_i,
    input  logic [XLEN-1:0]   rb_val_i,
    output logic              out_valid_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_val_o
);
    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    flow_dec_t       dec;
    logic            cond_hit;
    logic [XLEN-1:0] seq_pc, cond_tgt, rel_tgt, reg_tgt;
    logic [XLEN-1:0] nxt_pc;
    logic            nxt_taken;

    npc_decode u_dec (
        .opc_i (insn_i[INSN_W-1 -: OPC_W]),
        .dec_o (dec)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .a_i   (ra_val_i),
        .b_i   (rb_val_i),
        .cmp_i (dec.cmp),
        .hit_o (cond_hit)
    );

    npc_target #(.XLEN(XLEN)) u_tgt (
        .pc_i       (pc_i),
        .fld_i      (insn_i[JOFF_W-1:0]),
        .ra_i       (ra_val_i),
        .seq_o      (seq_pc),
        .cond_tgt_o (cond_tgt),
        .rel_tgt_o  (rel_tgt),
        .reg_tgt_o  (reg_tgt)
    );

    always_comb begin
        case (dec.flow)
            FLOW_COND: begin
                nxt_taken = cond_hit;
                nxt_pc    = cond_hit ? cond_tgt : seq_pc;
            end
            FLOW_REL: begin
                nxt_taken = 1'b1;
                nxt_pc    = rel_tgt;
            end
            FLOW_REG: begin
                nxt_taken = 1'b1;
                nxt_pc    = reg_tgt;
            end
            default: begin
                nxt_taken = 1'b0;
                nxt_pc    = seq_pc;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            next_pc_o   <= '0;
            taken_o     <= 1'b0;
            link_we_o   <= 1'b0;
            link_idx_o  <= '0;
            link_val_o  <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                next_pc_o  <= nxt_pc;
                taken_o    <= nxt_taken;
                link_we_o  <= dec.link;
                link_idx_o <= dec.link ? LINK_IDX : '0;
                link_val_o <= dec.link ? seq_pc : '0;
            end else begin
                taken_o    <= 1'b0;
                link_we_o  <= 1'b0;
                link_idx_o <= '0;
                link_val_o <= '0;
            end
        end
    end

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid_o == $past(in_valid_i && !rst)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> (!taken_o && !link_we_o)); // R2
    AST_FALLTHROUGH_SEQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4))); // R7
    AST_LINK_IMPLIES_TAKEN: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> taken_o); // R9
    AST_LINK_RETURN_ADDR: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == $past(pc_i) + XLEN'(4) && link_idx_o == LINK_IDX)); // R9
    AST_NO_LINK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !link_we_o |-> (link_idx_o == '0 && link_val_o == '0)); // R9
endmodule

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid_i;
    logic [31:0] pc_i, insn_i, ra_val_i, rb_val_i;
    logic        out_valid_o, taken_o, link_we_o;
    logic [31:0] next_pc_o, link_val_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    npc_unit dut_i (
        .clk (clk), .rst (rst), .in_valid_i (in_valid_i),
        .pc_i (pc_i), .insn_i (insn_i), .ra_val_i (ra_val_i), .rb_val_i (rb_val_i),
        .out_valid_o (out_valid_o), .next_pc_o (next_pc_o), .taken_o (taken_o),
        .link_we_o (link_we_o), .link_idx_o (link_idx_o), .link_val_o (link_val_o)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [25:0] fld;
        logic [31:0] pc;
        logic [31:0] ra;
        logic [31:0] rb;
        logic [31:0] npc;
        logic        tk;
        logic        lk;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{6'd17, 26'h0000004, 32'h00001000, 32'd5,         32'd5,         32'h00001010, 1'b1, 1'b0, 4'd3},  // R3 equal
        '{6'd17, 26'h0000004, 32'h00001000, 32'd5,         32'd6,         32'h00001004, 1'b0, 1'b0, 4'd7},  // R7
        '{6'd23, 26'h000FFFF, 32'h00001000, 32'd5,         32'd6,         32'h00000FFC, 1'b1, 1'b0, 4'd6},  // R6 back
        '{6'd18, 26'h0000008, 32'h00001000, 32'hFFFFFFFF,  32'd1,         32'h00001004, 1'b0, 1'b0, 4'd4},  // R4 signed
        '{6'd18, 26'h0000008, 32'h00001000, 32'd2,         32'd1,         32'h00001020, 1'b1, 1'b0, 4'd4},
        '{6'd19, 26'h0000001, 32'h00001000, 32'hFFFFFFFB,  32'hFFFFFFFB,  32'h00001004, 1'b1, 1'b0, 4'd4},
        '{6'd19, 26'h0000001, 32'h00001000, 32'h80000000,  32'h7FFFFFFF,  32'h00001004, 1'b0, 1'b0, 4'd4},
        '{6'd21, 26'h0000002, 32'h00001000, 32'hFFFFFFFF,  32'd1,         32'h00001008, 1'b1, 1'b0, 4'd5},  // R5
        '{6'd21, 26'h0000002, 32'h00001000, 32'd7,         32'd7,         32'h00001004, 1'b0, 1'b0, 4'd5},
        '{6'd20, 26'h0008000, 32'h00001000, 32'd7,         32'd7,         32'hFFFE1000, 1'b1, 1'b0, 4'd6},  // R6 min
        '{6'd20, 26'h0008000, 32'h00001000, 32'd0,         32'd1,         32'h00001004, 1'b0, 1'b0, 4'd5},
        '{6'd56, 26'h0000010, 32'h00001000, 32'd0,         32'd0,         32'h00001040, 1'b1, 1'b0, 4'd8},  // R8
        '{6'd56, 26'h3FFFFFF, 32'h00001000, 32'd0,         32'd0,         32'h00000FFC, 1'b1, 1'b0, 4'd8},
        '{6'd62, 26'h2000000, 32'h00001000, 32'd0,         32'd0,         32'hF8001000, 1'b1, 1'b1, 4'd8},
        '{6'd62, 26'h0000100, 32'h00400000, 32'd0,         32'd0,         32'h00400400, 1'b1, 1'b1, 4'd9},  // R9
        '{6'd48, 26'h3A00000, 32'h00001000, 32'h12345677,  32'd0,         32'h12345674, 1'b1, 1'b0, 4'd10}, // R10 return
        '{6'd54, 26'h0000000, 32'h00001000, 32'h0000ABCD,  32'd0,         32'h0000ABCC, 1'b1, 1'b1, 4'd10},
        '{6'd45, 26'h0000000, 32'h00001000, 32'd1,         32'd2,         32'h00001004, 1'b0, 1'b0, 4'd11}, // R11
        '{6'd10, 26'h00000FF, 32'h00002000, 32'd9,         32'd9,         32'h00002004, 1'b0, 1'b0, 4'd11},
        '{6'd17, 26'h0000001, 32'hFFFFFFFC, 32'd3,         32'd3,         32'h00000000, 1'b1, 1'b0, 4'd12}, // R12
        '{6'd23, 26'h0000001, 32'hFFFFFFFC, 32'd3,         32'd3,         32'h00000000, 1'b0, 1'b0, 4'd12}
    };

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic present(input logic [5:0] op, input logic [25:0] fld, input logic [31:0] pc,
                           input logic [31:0] ra, input logic [31:0] rb);
        in_valid_i = 1'b1;
        insn_i     = {op, fld};
        pc_i       = pc;
        ra_val_i   = ra;
        rb_val_i   = rb;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        rst = 1'b1; in_valid_i = 1'b0;
        pc_i = '0; insn_i = '0; ra_val_i = '0; rb_val_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", 32'(out_valid_o), 32'd0);
        check("R1", "taken", 32'(taken_o), 32'd0);
        check("R1", "link_we", 32'(link_we_o), 32'd0);
        check("R1", "next_pc", next_pc_o, 32'd0);
        check("R1", "link_idx", 32'(link_idx_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i].req);
            present(VECS[i].op, VECS[i].fld, VECS[i].pc, VECS[i].ra, VECS[i].rb);
            check("R2", "out_valid", 32'(out_valid_o), 32'd1);
            check(rq, $sformatf("vec %0d next_pc", i), next_pc_o, VECS[i].npc);
            check(rq, $sformatf("vec %0d taken", i), 32'(taken_o), 32'(VECS[i].tk));
            check("R9", $sformatf("vec %0d link_we", i), 32'(link_we_o), 32'(VECS[i].lk));
            if (VECS[i].lk) begin
                check("R9", "link_idx", 32'(link_idx_o), 32'd29);
                check("R9", "link_val", link_val_o, VECS[i].pc + 32'd4);
            end else begin
                check("R9", "link_val idle", link_val_o, 32'd0);
            end
        end

        // R2: an idle cycle after a call clears the flags
        present(6'd62, 26'h0000001, 32'h00003000, 32'd0, 32'd0);
        check("R9", "call link_we", 32'(link_we_o), 32'd1);
        @(negedge clk);
        check("R2", "idle out_valid", 32'(out_valid_o), 32'd0);
        check("R2", "idle taken", 32'(taken_o), 32'd0);
        check("R2", "idle link_we", 32'(link_we_o), 32'd0);

        // R2: back-to-back instructions, each answered one edge later
        in_valid_i = 1'b1; insn_i = {6'd56, 26'h0000004}; pc_i = 32'h00005000;
        @(negedge clk);
        check("R8", "b2b first", next_pc_o, 32'h00005010);
        insn_i = {6'd48, 26'h0}; ra_val_i = 32'h00007003;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R10", "b2b second", next_pc_o, 32'h00007000);
        check("R2", "b2b valid", 32'(out_valid_o), 32'd1);

        // R1: reset after activity clears outputs
        present(6'd54, 26'h0, 32'h00001000, 32'h00000100, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "reset next_pc", next_pc_o, 32'd0);
        check("R1", "reset link_we", 32'(link_we_o), 32'd0);
        check("R1", "reset valid", 32'(out_valid_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule